// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register

This block is the digital front end of an eight-channel, 13-bit parallel-input digital-to-analog converter. A processor-style bus drives it with a data word, a channel address and four active-low controls: chip select, write, load and clear. Each channel stores its code in two stages. The first stage captures bus data for the addressed channel. The second stage takes the first stage's contents for every channel at once, so all eight outputs can change together.

Both stages act like transparent latches. While a stage is open, its view follows its source combinationally. When the stage closes, it holds the value it took at the last clock edge before closing. When chip select, write and load are all low together, bus data flows straight through both stages to the addressed channel's output, with no register in the path. Clear drives a force-to-ground flag on every channel and leaves all stored codes alone. A small combinational helper turns a two's complement word into the offset binary code the block stores.

Top module: `dac8_dbuf`

## Requirements
- R1: After `rst_ni` is asserted, every stored code in both stages is zero, so all eight `dac_code_o` fields read 0.
- R2: While `cs_ni` and `wr_ni` are both low, the addressed channel's first stage follows `data_i`. When either signal is high, that stage keeps its last captured value.
- R3: A write leaves the first stage of every non-addressed channel unchanged.
- R4: While `ld_ni` is high, the second stage holds. A write then changes no `dac_code_o` field.
- R5: While `ld_ni` is low, every channel's output follows its first stage. Raising `ld_ni` keeps those values on all eight channels together.
- R6: With `cs_ni`, `wr_ni` and `ld_ni` all low, the addressed channel's `dac_code_o` field equals `data_i` in the same cycle, with no clock edge needed.
- R7: While `clr_ni` is low, every bit of `gnd_force_o` is 1 and `dac_code_o` is unchanged. Releasing `clr_ni` clears `gnd_force_o` and leaves the earlier codes in place.
- R8: While `wr_ni` or `cs_ni` is high, changing `addr_i` and `data_i` alters no stored code.
- R9: `ob_code_o` equals `tc_code_i + 4096` modulo 8192. This is the same as inverting bit 12.
- R10: Address value k selects channel k. Channel k's code appears on `dac_code_o[13*k+12 : 13*k]`. Code 0 stands for the negative reference and code 0x1FFF for roughly the positive reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the storage stages |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 13 | Bus data word, offset binary |
| addr_i | input | 3 | Channel address |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ld_ni | input | 1 | Load, active low; opens all second stages |
| clr_ni | input | 1 | Clear, active low; forces outputs to ground |
| dac_code_o | output | 104 | Eight 13-bit output codes, channel k in bits 13k+12:13k |
| gnd_force_o | output | 8 | Per-channel force-to-ground flag |
| tc_code_i | input | 13 | Two's complement word for the helper |
| ob_code_o | output | 13 | Offset binary form of tc_code_i |

## Verification
The assertions check the stage behaviour on every clock. An unselected or closed first stage must not change. A selected first stage must take the bus word. A closed second stage must hold, and an open one must take its first-stage view. The code helper's arithmetic is checked against a separate addition. Behaviour that shows up only between clock edges or over a sequence of steps is left to the bench scenarios. These include flow-through with no clock, all channels moving together on load, clear being asserted and then released with the codes kept, and address sweeps while the write is held off.

// File: rtl/dac8_pkg.sv
package dac8_pkg;
  localparam int unsigned DEF_DW  = 13;
  localparam int unsigned DEF_NCH = 8;

  typedef enum logic [1:0] {
    PATH_HOLD = 2'd0,
    PATH_LOAD = 2'd1,
    PATH_FLOW = 2'd2
  } path_e;

  function automatic path_e path_of(input logic we, input logic ld_open);
    if (we && ld_open) return PATH_FLOW;
    if (ld_open)       return PATH_LOAD;
    return PATH_HOLD;
  endfunction
endpackage

// File: rtl/dac8_addr_dec.sv
module dac8_addr_dec #(
  parameter int unsigned NCH = 8,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  output logic [NCH-1:0] sel_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel_o[c] = we_i && (addr_i == AW'(c));
  end
endmodule

// File: rtl/dac8_in_rank.sv
module dac8_in_rank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCH-1:0]      sel_i,
  input  logic [DW-1:0]       data_i,
  output logic [NCH-1:0][DW-1:0] view_o
);
  logic [NCH-1:0][DW-1:0] in_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       in_q[c] <= '0;
      else if (sel_i[c]) in_q[c] <= data_i;
    end
    // transparent while selected
    assign view_o[c] = sel_i[c] ? data_i : in_q[c];

    // R2
    in_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[c] |=> in_q[c] == $past(data_i));
    // R3
    in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[c] |=> $stable(in_q[c]));
  end
endmodule

// File: rtl/dac8_out_rank.sv
module dac8_out_rank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 13
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_open_i,
  input  logic [NCH-1:0][DW-1:0] src_i,
  output logic [NCH-1:0][DW-1:0] code_o
);
  logic [NCH-1:0][DW-1:0] dac_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dac_q[c] <= '0;
      else if (ld_open_i) dac_q[c] <= src_i[c];
    end
    assign code_o[c] = ld_open_i ? src_i[c] : dac_q[c];

    // R4
    dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_open_i |=> $stable(dac_q[c]));
    // R5
    dac_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_open_i |=> dac_q[c] == $past(src_i[c]));
  end
endmodule

// File: rtl/dac8_code_conv.sv
module dac8_code_conv #(
  parameter int unsigned DW = 13
) (
  input  logic [DW-1:0] tc_i,
  output logic [DW-1:0] ob_o
);
  localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);

  assign ob_o = {~tc_i[DW-1], tc_i[DW-2:0]};

  // R9
  always_comb begin
    conv_sum_chk: assert (ob_o == DW'(tc_i + HALF));
  end
endmodule

// File: rtl/dac8_dbuf.sv
module dac8_dbuf
  import dac8_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned DW  = DEF_DW,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     data_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              ld_ni,
  input  logic              clr_ni,
  output logic [NCH*DW-1:0] dac_code_o,
  output logic [NCH-1:0]    gnd_force_o,
  input  logic [DW-1:0]     tc_code_i,
  output logic [DW-1:0]     ob_code_o
);
  logic                   we;
  logic                   ld_open;
  logic [NCH-1:0]         sel;
  logic [NCH-1:0][DW-1:0] in_view;
  logic [NCH-1:0][DW-1:0] code;
  path_e                  path;

  assign we      = !cs_ni && !wr_ni;
  assign ld_open = !ld_ni;
  assign path    = path_of(we, ld_open);

  dac8_addr_dec #(.NCH(NCH)) u_dec (
    .addr_i(addr_i), .we_i(we), .sel_o(sel)
  );

  dac8_in_rank #(.NCH(NCH), .DW(DW)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .data_i(data_i), .view_o(in_view)
  );

  dac8_out_rank #(.NCH(NCH), .DW(DW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_open_i(ld_open), .src_i(in_view), .code_o(code)
  );

  dac8_code_conv #(.DW(DW)) u_conv (
    .tc_i(tc_code_i), .ob_o(ob_code_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign dac_code_o[c*DW +: DW] = code[c];
    assign gnd_force_o[c]         = !clr_ni;
  end

  // R6
  flow_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path == PATH_FLOW) |-> code[addr_i] == data_i);
  // R7
  clr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> gnd_force_o == '1);
endmodule

// File: tb/tb_dac8_dbuf.sv
module tb_dac8_dbuf;
  localparam int NCH = 8;
  localparam int DW  = 13;

  logic clk = 0;
  logic rst_ni = 0;
  logic [DW-1:0] data = '0;
  logic [2:0] addr = '0;
  logic cs_n = 1, wr_n = 1, ld_n = 1, clr_n = 1;
  logic [NCH*DW-1:0] code;
  logic [NCH-1:0] gforce;
  logic [DW-1:0] tc = '0, ob;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_in  [NCH];
  logic [DW-1:0] exp_dac [NCH];

  always #5 clk = ~clk;

  dac8_dbuf dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .addr_i(addr),
    .cs_ni(cs_n), .wr_ni(wr_n), .ld_ni(ld_n), .clr_ni(clr_n),
    .dac_code_o(code), .gnd_force_o(gforce), .tc_code_i(tc), .ob_code_o(ob)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < NCH; c++)
      chk(code[c*DW +: DW] == exp_dac[c], req, int'(code[c*DW +: DW]), int'(exp_dac[c]));
  endtask

  task automatic do_write(input int ch, input logic [DW-1:0] d);
    @(negedge clk);
    addr = 3'(ch); data = d; cs_n = 0; wr_n = 0;
    @(posedge clk); #1;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    exp_in[ch] = d;
  endtask

  task automatic do_load();
    @(negedge clk);
    ld_n = 0;
    #1;
    for (int c = 0; c < NCH; c++) exp_dac[c] = exp_in[c];
    chk_all("R5 open");
    @(posedge clk); #1;
    @(negedge clk);
    ld_n = 1;
    #1;
    chk_all("R5 held");
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    #1;
    chk_all("R1 reset");
    chk(gforce == '0, "R1 flag", int'(gforce), 0);

    // R2 R3 R4 R10: writes with load held off
    for (int c = 0; c < NCH; c++) begin
      do_write(c, DW'(13'h0101 * (c + 1) + 13'h0a5));
      #1;
      chk_all("R4 write no effect");
    end
    // R5 R10: simultaneous transfer, channel k in slice k
    do_load();

    // R3: overwrite channel 2 only, then load
    do_write(2, 13'h1FFF);
    do_load();
    do_write(6, 13'h0000);
    do_load();

    // R6: flow-through with no clock edge
    @(negedge clk);
    ld_n = 0; addr = 3'd5; data = 13'h1234; cs_n = 0; wr_n = 0;
    #1;
    chk(code[5*DW +: DW] == 13'h1234, "R6 flow", int'(code[5*DW +: DW]), 'h1234);
    data = 13'h0777;
    #1;
    chk(code[5*DW +: DW] == 13'h0777, "R6 flow follow", int'(code[5*DW +: DW]), 'h777);
    @(posedge clk); #1;
    @(negedge clk);
    cs_n = 1; wr_n = 1; ld_n = 1;
    exp_in[5] = 13'h0777; exp_dac[5] = 13'h0777;
    #1;
    chk_all("R6 after flow");

    // R8: address and data sweep with the write held off
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk);
      cs_n = pass[0]; wr_n = !pass[0]; ld_n = 1;
      for (int a = 0; a < NCH; a++) begin
        @(negedge clk);
        addr = 3'(a); data = DW'(13'h1ABC ^ (a * 37));
      end
      @(negedge clk);
      cs_n = 1; wr_n = 1;
      #1;
      chk_all("R8 no write");
      do_load();
    end

    // R7: clear keeps codes
    @(negedge clk);
    clr_n = 0;
    #1;
    chk(gforce == '1, "R7 flag on", int'(gforce), 'hff);
    chk_all("R7 codes kept");
    repeat (3) @(posedge clk);
    do_write(1, 13'h0042);
    chk(gforce == '1, "R7 flag held", int'(gforce), 'hff);
    @(negedge clk);
    clr_n = 1;
    #1;
    chk(gforce == '0, "R7 flag off", int'(gforce), 0);
    chk_all("R7 restore");
    do_load();

    // R9: exhaustive converter sweep
    for (int v = 0; v < (1 << DW); v++) begin
      tc = DW'(v);
      #1;
      chk(ob == DW'((v + 4096) % 8192), "R9 conv", int'(ob), (v + 4096) % 8192);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule